// File: doc/BRIEF.md
# Two-Level Cache Tag Directory with Selectable Inclusion Policy

This block models the tag side of a two-level cache hierarchy for read traffic. A requester presents a 32-bit byte address, and the block answers with one hit/miss flag for the first level and one for the second level. No data is stored. Each level keeps its own valid bits, tags and per-set least-recently-used ordering. The block performs every fill, eviction and level-to-level move that the selected policy requires.

The `mode_excl` input selects the policy. It is changed only while reset is held. When it is low, the second level is inclusive: a first-level miss fills the second level as well, and a block dropped by the second level is also removed from the first level. When it is high, the second level is exclusive: it holds only blocks that the first level has evicted. A second-level hit moves the block up and removes it from the second level.

Capacities, associativities (1, 2 or 4 ways) and block sizes are elaboration parameters. The second level must be larger than the first level. Its block size must be at least that of the first level, and exactly equal to it for exclusive use. Requests are handled one at a time behind a valid/ready handshake.

Top module: `twolvl_dir`

## Requirements
- R1: Reset leaves `req_ready` high and `resp_valid` low, and it invalidates every line at both levels, so the first access to any address after reset reports a miss at both levels.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low during the following cycle. `resp_valid` is high for exactly one cycle, starting at the second edge after acceptance.
- R3: When a lookup hits in the first level, the response has `resp_l1_hit`=1 and `resp_l2_hit`=0.
- R4: Byte-offset bits inside a block do not affect a lookup. Blocks that map to different sets do not displace one another.
- R5: The first level fills an invalid way before it replaces a valid one. Otherwise it replaces the least recently used way of the set, where a hit or a fill makes a way the most recently used.
- R6: The second level selects its replacement way by the same rule as R5. A first-level hit does not change the second-level ordering.
- R7: In inclusive mode, a miss at both levels fills the block into both levels. A block replaced in the first level stays in the second level, so it reports a second-level hit on its next access.
- R8: In inclusive mode, when the second level replaces a valid block, every first-level line that lies inside that block is invalidated in the same operation.
- R9: In exclusive mode, a miss at both levels fills only the first level. A valid first-level victim is written into the second level as the most recently used way of its set.
- R10: In exclusive mode, a second-level hit fills the first level and removes the block from the second level. When the first-level victim maps to that same second-level set, it takes the freed way in the same operation.
- R11: `mode_excl` holds its value whenever reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_excl | input | 1 | Policy select: 0 inclusive, 1 exclusive; static outside reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 32 | Byte address of the read |
| resp_valid | output | 1 | One-cycle pulse carrying the lookup result |
| resp_l1_hit | output | 1 | First-level hit for the answered request |
| resp_l2_hit | output | 1 | Second-level hit; 0 whenever the first level hit |

## Verification
The riskiest cycle is the one in which a single operation writes two different things into the same set. Two cases produce it. In inclusive mode, the second-level replacement can back-invalidate a first-level line in the same cycle that the first level fills a different way of that set. In exclusive mode, removing a block from a second-level set can coincide with writing the first-level victim into that same set. The bench provokes the first case by repeatedly hitting one block in the first level until its second-level copy becomes least recently used, then missing on a new block in the same sets. It provokes the second case by streaming more blocks through one set than either level holds alone. In both cases the later hit/miss pattern at the ports shows whether both writes landed.

// File: rtl/twolvl_pkg.sv
package twolvl_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WORK = 1'b1
  } twolvl_state_e;

  function automatic int way_bits(input int ways);
    return (ways > 1) ? $clog2(ways) : 1;
  endfunction
endpackage

// File: rtl/twolvl_victim.sv
module twolvl_victim #(
  parameter int WAYS = 2,
  parameter int AW   = 1
) (
  input  logic [WAYS-1:0]    vld,
  input  logic [WAYS*AW-1:0] ages,
  output logic [AW-1:0]      way
);
  always_comb begin
    way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (ages[w*AW +: AW] == AW'(WAYS - 1)) way = AW'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[w]) way = AW'(w);
    end
  end
endmodule

// File: rtl/twolvl_level.sv
module twolvl_level
  import twolvl_pkg::*;
#(
  parameter int SETS = 8,
  parameter int WAYS = 2,
  parameter int TAGW = 25,
  parameter int NINV = 1,
  localparam int IW  = $clog2(SETS),
  localparam int AW  = way_bits(WAYS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IW-1:0]      lk_set,
  input  logic [TAGW-1:0]    lk_tag,
  output logic               lk_hit,
  output logic [AW-1:0]      lk_way,
  output logic [AW-1:0]      vic_way,
  output logic               vic_valid,
  output logic [TAGW-1:0]    vic_tag,
  input  logic [IW-1:0]      pr_set,
  output logic [AW-1:0]      pr_way,
  input  logic [NINV-1:0]    inv_en,
  input  logic [NINV*IW-1:0] inv_set,
  input  logic [NINV*TAGW-1:0] inv_tag,
  input  logic               upd_en,
  input  logic               upd_fill,
  input  logic [IW-1:0]      upd_set,
  input  logic [AW-1:0]      upd_way,
  input  logic [TAGW-1:0]    upd_tag
);
  logic [WAYS-1:0]    vld_q [SETS];
  logic [TAGW-1:0]    tag_q [SETS][WAYS];
  logic [AW-1:0]      age_q [SETS][WAYS];
  logic [WAYS*AW-1:0] lk_ages;
  logic [WAYS*AW-1:0] pr_ages;

  always_comb begin
    lk_hit = 1'b0;
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      lk_ages[w*AW +: AW] = age_q[lk_set][w];
      pr_ages[w*AW +: AW] = age_q[pr_set][w];
      if (vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag)) begin
        lk_hit = 1'b1;
        lk_way = AW'(w);
      end
    end
  end

  twolvl_victim #(.WAYS(WAYS), .AW(AW)) i_vic_lk (
    .vld (vld_q[lk_set]),
    .ages(lk_ages),
    .way (vic_way)
  );

  twolvl_victim #(.WAYS(WAYS), .AW(AW)) i_vic_pr (
    .vld (vld_q[pr_set]),
    .ages(pr_ages),
    .way (pr_way)
  );

  assign vic_valid = vld_q[lk_set][vic_way];
  assign vic_tag   = tag_q[lk_set][vic_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          age_q[s][w] <= AW'(w);
        end
      end
    end else begin
      for (int k = 0; k < NINV; k++) begin
        if (inv_en[k]) begin
          for (int w = 0; w < WAYS; w++) begin
            if (vld_q[inv_set[k*IW +: IW]][w] &&
                (tag_q[inv_set[k*IW +: IW]][w] == inv_tag[k*TAGW +: TAGW]))
              vld_q[inv_set[k*IW +: IW]][w] <= 1'b0;
          end
        end
      end
      if (upd_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (AW'(w) == upd_way) begin
            age_q[upd_set][w] <= '0;
            if (upd_fill) begin
              vld_q[upd_set][w] <= 1'b1;
              tag_q[upd_set][w] <= upd_tag;
            end
          end else if (age_q[upd_set][w] < age_q[upd_set][upd_way]) begin
            age_q[upd_set][w] <= age_q[upd_set][w] + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/twolvl_dir.sv
module twolvl_dir
  import twolvl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_BYTES = 256,
  parameter int L1_WAYS  = 2,
  parameter int L1_BLK   = 16,
  parameter int L2_BYTES = 1024,
  parameter int L2_WAYS  = 4,
  parameter int L2_BLK   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_excl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic              resp_l1_hit,
  output logic              resp_l2_hit
);
  localparam int L1_SETS = L1_BYTES / (L1_BLK * L1_WAYS);
  localparam int L2_SETS = L2_BYTES / (L2_BLK * L2_WAYS);
  localparam int O1      = $clog2(L1_BLK);
  localparam int I1      = $clog2(L1_SETS);
  localparam int T1      = ADDR_W - O1 - I1;
  localparam int O2      = $clog2(L2_BLK);
  localparam int I2      = $clog2(L2_SETS);
  localparam int T2      = ADDR_W - O2 - I2;
  localparam int RATIO   = L2_BLK / L1_BLK;
  localparam int W1      = way_bits(L1_WAYS);
  localparam int W2      = way_bits(L2_WAYS);

  twolvl_state_e     state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              work;

  logic [I1-1:0] set1;
  logic [T1-1:0] tag1;
  logic [I2-1:0] set2;
  logic [T2-1:0] tag2;

  logic          l1_hit, l1_vvld;
  logic [W1-1:0] l1_hway, l1_vway, l1_pway_unused;
  logic [T1-1:0] l1_vtag;
  logic          l2_hit, l2_vvld;
  logic [W2-1:0] l2_hway, l2_vway, l2_pway;
  logic [T2-1:0] l2_vtag;

  logic [ADDR_W-1:0] vic_addr;
  logic [I2-1:0]     vset2;
  logic [T2-1:0]     vtag2;
  logic [ADDR_W-1:0] ev_addr;

  logic [RATIO-1:0]    l1_inv_en;
  logic [RATIO*I1-1:0] l1_inv_set;
  logic [RATIO*T1-1:0] l1_inv_tag;

  logic          l2_upd_en, l2_upd_fill;
  logic [I2-1:0] l2_upd_set;
  logic [W2-1:0] l2_upd_way;
  logic [T2-1:0] l2_upd_tag;
  logic          l2_kill;

  assign req_ready = (state_q == ST_IDLE);
  assign work      = (state_q == ST_WORK);

  assign set1 = addr_q[O1 +: I1];
  assign tag1 = addr_q[ADDR_W-1 -: T1];
  assign set2 = addr_q[O2 +: I2];
  assign tag2 = addr_q[ADDR_W-1 -: T2];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      resp_valid  <= 1'b0;
      resp_l1_hit <= 1'b0;
      resp_l2_hit <= 1'b0;
    end else begin
      resp_valid  <= work;
      resp_l1_hit <= work && l1_hit;
      resp_l2_hit <= work && !l1_hit && l2_hit;
      if (work) begin
        state_q <= ST_IDLE;
      end else if (req_valid) begin
        state_q <= ST_WORK;
        addr_q  <= req_addr;
      end
    end
  end

  // Victim of the first level re-expressed in second-level coordinates.
  assign vic_addr = {l1_vtag, set1, {O1{1'b0}}};
  assign vset2    = vic_addr[O2 +: I2];
  assign vtag2    = vic_addr[ADDR_W-1 -: T2];

  // Block leaving the second level, split into first-level lines.
  assign ev_addr = {l2_vtag, set2, {O2{1'b0}}};

  for (genvar k = 0; k < RATIO; k++) begin : g_binv
    logic [ADDR_W-1:0] sub_addr;
    assign sub_addr = ev_addr + ADDR_W'(k * L1_BLK);
    assign l1_inv_set[k*I1 +: I1] = sub_addr[O1 +: I1];
    assign l1_inv_tag[k*T1 +: T1] = sub_addr[ADDR_W-1 -: T1];
    assign l1_inv_en[k] = work && !mode_excl && !l1_hit && !l2_hit && l2_vvld;
  end

  twolvl_level #(
    .SETS(L1_SETS), .WAYS(L1_WAYS), .TAGW(T1), .NINV(RATIO)
  ) i_l1 (
    .clk      (clk),
    .rst      (rst),
    .lk_set   (set1),
    .lk_tag   (tag1),
    .lk_hit   (l1_hit),
    .lk_way   (l1_hway),
    .vic_way  (l1_vway),
    .vic_valid(l1_vvld),
    .vic_tag  (l1_vtag),
    .pr_set   (set1),
    .pr_way   (l1_pway_unused),
    .inv_en   (l1_inv_en),
    .inv_set  (l1_inv_set),
    .inv_tag  (l1_inv_tag),
    .upd_en   (work),
    .upd_fill (!l1_hit),
    .upd_set  (set1),
    .upd_way  (l1_hit ? l1_hway : l1_vway),
    .upd_tag  (tag1)
  );

  assign l2_kill = work && mode_excl && !l1_hit && l2_hit;

  always_comb begin
    l2_upd_en   = 1'b0;
    l2_upd_fill = 1'b0;
    l2_upd_set  = set2;
    l2_upd_way  = l2_hit ? l2_hway : l2_vway;
    l2_upd_tag  = tag2;
    if (work && !l1_hit) begin
      if (!mode_excl) begin
        l2_upd_en   = 1'b1;
        l2_upd_fill = !l2_hit;
      end else if (l1_vvld) begin
        l2_upd_en   = 1'b1;
        l2_upd_fill = 1'b1;
        l2_upd_set  = vset2;
        l2_upd_tag  = vtag2;
        l2_upd_way  = (l2_hit && (vset2 == set2)) ? l2_hway : l2_pway;
      end
    end
  end

  twolvl_level #(
    .SETS(L2_SETS), .WAYS(L2_WAYS), .TAGW(T2), .NINV(1)
  ) i_l2 (
    .clk      (clk),
    .rst      (rst),
    .lk_set   (set2),
    .lk_tag   (tag2),
    .lk_hit   (l2_hit),
    .lk_way   (l2_hway),
    .vic_way  (l2_vway),
    .vic_valid(l2_vvld),
    .vic_tag  (l2_vtag),
    .pr_set   (vset2),
    .pr_way   (l2_pway),
    .inv_en   (l2_kill),
    .inv_set  (set2),
    .inv_tag  (tag2),
    .upd_en   (l2_upd_en),
    .upd_fill (l2_upd_fill),
    .upd_set  (l2_upd_set),
    .upd_way  (l2_upd_way),
    .upd_tag  (l2_upd_tag)
  );
endmodule

// File: rtl/twolvl_dir_chk.sv
module twolvl_dir_chk (
  input logic clk,
  input logic rst,
  input logic mode_excl,
  input logic req_valid,
  input logic req_ready,
  input logic resp_valid,
  input logic resp_l1_hit,
  input logic resp_l2_hit
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (req_ready && !resp_valid));

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && !resp_valid));

  p_resp_timing_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> ##1 resp_valid);

  p_resp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  p_l1hit_flag_r3: assert property (@(posedge clk) disable iff (rst)
    resp_l1_hit |-> (resp_valid && !resp_l2_hit));

  p_l2hit_in_resp_r3: assert property (@(posedge clk) disable iff (rst)
    resp_l2_hit |-> resp_valid);

  p_mode_static_r11: assert property (@(posedge clk) disable iff (rst)
    !$fell(rst) |-> $stable(mode_excl));
endmodule

bind twolvl_dir twolvl_dir_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_excl  (mode_excl),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_l1_hit(resp_l1_hit),
  .resp_l2_hit(resp_l2_hit)
);

// File: tb/test_twolvl_dir.sv
module test_twolvl_dir;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_excl = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        resp_valid;
  logic        resp_l1_hit;
  logic        resp_l2_hit;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  twolvl_dir i_twolvl_dir (
    .clk        (clk),
    .rst        (rst),
    .mode_excl  (mode_excl),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .resp_valid (resp_valid),
    .resp_l1_hit(resp_l1_hit),
    .resp_l2_hit(resp_l2_hit)
  );

  // Entry: [39] reset first, [38] mode, [37:34] requirement, [33:2] address, [1] L1 hit, [0] L2 hit
  localparam int NV = 42;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd7,  32'h000, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd3,  32'h000, 1'b1, 1'b0},
    {1'b0, 1'b0, 4'd7,  32'h100, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd5,  32'h200, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd7,  32'h000, 1'b0, 1'b1},
    {1'b0, 1'b0, 4'd6,  32'h300, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd6,  32'h400, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd6,  32'h100, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd3,  32'h400, 1'b1, 1'b0},
    {1'b0, 1'b0, 4'd7,  32'h000, 1'b0, 1'b1},
    {1'b0, 1'b0, 4'd3,  32'h400, 1'b1, 1'b0},
    {1'b0, 1'b0, 4'd6,  32'h200, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd3,  32'h400, 1'b1, 1'b0},
    {1'b0, 1'b0, 4'd8,  32'h300, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd8,  32'h400, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd8,  32'h300, 1'b1, 1'b0},
    {1'b0, 1'b0, 4'd7,  32'h200, 1'b0, 1'b1},
    {1'b0, 1'b0, 4'd4,  32'h010, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd4,  32'h01C, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'd9,  32'h000, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd9,  32'h100, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd9,  32'h200, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd9,  32'h300, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd9,  32'h400, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd9,  32'h500, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd10, 32'h000, 1'b0, 1'b1},
    {1'b0, 1'b1, 4'd10, 32'h100, 1'b0, 1'b1},
    {1'b0, 1'b1, 4'd10, 32'h200, 1'b0, 1'b1},
    {1'b0, 1'b1, 4'd10, 32'h300, 1'b0, 1'b1},
    {1'b0, 1'b1, 4'd10, 32'h400, 1'b0, 1'b1},
    {1'b0, 1'b1, 4'd10, 32'h500, 1'b0, 1'b1},
    {1'b0, 1'b1, 4'd3,  32'h500, 1'b1, 1'b0},
    {1'b0, 1'b1, 4'd5,  32'h400, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'd9,  32'h000, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd9,  32'h100, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd9,  32'h200, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd9,  32'h300, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd9,  32'h400, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd9,  32'h500, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd9,  32'h600, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd10, 32'h100, 1'b0, 1'b1},
    {1'b0, 1'b1, 4'd9,  32'h000, 1'b0, 1'b0}
  };

  function automatic string rname(input logic [3:0] c);
    case (c)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string rq, input logic [2:0] act, input logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", rq, act, exp, $time);
    end
  endtask

  // R11: the mode only moves while reset is asserted
  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1;
    mode_excl = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Returns {resp_valid, resp_l1_hit, resp_l2_hit} two edges after acceptance.
  task automatic access(input logic [31:0] a, output logic [2:0] r);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    r = {resp_valid, resp_l1_hit, resp_l2_hit};
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [2:0] r;
    do_reset(1'b0);
    // R1: idle after reset
    @(negedge clk);
    chk("R1", {req_ready, resp_valid, resp_l1_hit}, 3'b100);

    // R2: handshake timing, sampled cycle by cycle
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 32'h0000_0040;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", {req_ready, resp_valid, 1'b0}, 3'b000);
    @(negedge clk);
    chk("R2", {req_ready, resp_valid, 1'b0}, 3'b110);
    @(negedge clk);
    chk("R2", {req_ready, resp_valid, 1'b0}, 3'b100);

    // R1: reset drops every line
    access(32'h0000_0040, r);
    chk("R3", r, 3'b110);
    do_reset(1'b0);
    access(32'h0000_0040, r);
    chk("R1", r, 3'b100);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][39]) do_reset(VEC[i][38]);
      access(VEC[i][33:2], r);
      chk(rname(VEC[i][37:34]), r, {1'b1, VEC[i][1:0]});
    end

    // R4: a block in another set survives a full sweep of set 0
    do_reset(1'b0);
    access(32'h0000_0020, r);
    for (int k = 0; k < 6; k++) access(32'(k * 256), r);
    access(32'h0000_002F, r);
    chk("R4", r, 3'b110);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule